// File: doc/BRIEF.md
# Dual-Rate Serial Baud Tick Generator

This block turns the bus clock into two independent clock-enable streams, one pacing the transmit side and one pacing the receive side of an asynchronous serial port. Each stream is a single-cycle pulse that repeats every N bus clocks. The value of N is set by a shared first-stage prescaler with non-binary factors, a per-path power-of-two divisor, and an optional per-path 8-bit fine-tuning multiplier.

Software-side logic writes three 8-bit registers through strobe/data pairs. The first is a rate register holding the prescaler select and both divisor selects. The other two are the transmit and receive fine-tuning factors. Each path counts down from its total division minus one and pulses its tick at zero. A register write restarts the affected path on the following clock, so a new rate takes effect at once instead of after the old period runs out.

Top module: `rate_tick_gen`

## Requirements
- R1: The rate register splits into three fields. Bits 2:0 are the receive divisor select, bits 5:3 the transmit divisor select, and bits 7:6 the prescaler select. It is loaded from rateData on the clock edge where rateWe is high.
- R2: The prescaler select chooses a factor. Code 2'b00 gives 1, 2'b01 gives 3, 2'b10 gives 4 and 2'b11 gives 13.
- R3: A divisor select value s (0 to 7) gives a divisor of 2 to the power s, so 1, 2, 4 and so on up to 128. The transmit and receive selects act independently of each other.
- R4: With both fine factors at zero, the transmit period in clocks is the prescaler factor times the transmit divisor. The receive period is the prescaler factor times the receive divisor.
- R5: A nonzero fine factor F on a path (txFineData/txFineWe or rxFineData/rxFineWe) multiplies that path's period by F. A fine factor of 0 leaves the plain period in force.
- R6: Reset clears the rate register and both fine factors to zero, which sets a period of 1 on both paths.
- R7: While the settings are unchanged, each tick is high for one clock per period. Consecutive ticks of a path are exactly N clocks apart, where N is that path's period.
- R8: After a write on clock edge E, the affected path reloads on edge E+1. Its tick is then low for the next N-1 clocks and first goes high in the clock that follows edge E+N. A rate write affects both paths; a fine write affects only its own path.
- R9: A path whose period is 1 holds its tick high on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateWe | input | 1 | Write strobe for the rate register |
| rateData | input | 8 | Rate register write data |
| txFineWe | input | 1 | Write strobe for the transmit fine factor |
| txFineData | input | 8 | Transmit fine factor write data |
| rxFineWe | input | 1 | Write strobe for the receive fine factor |
| rxFineData | input | 8 | Receive fine factor write data |
| txTick | output | 1 | Transmit rate enable pulse |
| rxTick | output | 1 | Receive rate enable pulse |

## Verification
The hardest case to reach from the ports is the interaction of a new setting with a counter that is partway through a long old period. That is where a missed reload would show up as a late first tick. The stimulus therefore applies each new setting while the previous period is still running, with mixed prescaler, divisor and fine values drawn at random under a period cap. For each setting it compares every clock of both tick streams against the expected pattern, from the reload edge through two full periods. Directed cases cover the largest plain period, each prescaler code on its own, unequal transmit and receive selects, and period 1.

// File: rtl/rate_tick_pkg.sv
package rate_tick_pkg;

  typedef struct packed {
    logic reloadTx;
    logic reloadRx;
  } ctrlStrobes_t;

  // Non-binary first-stage prescale factors (R2)
  function automatic logic [3:0] preFactor(input logic [1:0] sel);
    case (sel)
      2'b00:   preFactor = 4'd1;
      2'b01:   preFactor = 4'd3;
      2'b10:   preFactor = 4'd4;
      default: preFactor = 4'd13;
    endcase
  endfunction

endpackage

// File: rtl/rate_tick_ctrl.sv
module rate_tick_ctrl
  import rate_tick_pkg::*;
#(
  parameter int RATE_W    = 8,
  parameter int FINE_W    = 8,
  parameter int PRE_SEL_W = 2,
  parameter int DIV_SEL_W = 3,
  parameter int CNT_W     = 4 + (2**DIV_SEL_W - 1) + FINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateWe,
  input  logic [RATE_W-1:0] rateData,
  input  logic              txFineWe,
  input  logic [FINE_W-1:0] txFineData,
  input  logic              rxFineWe,
  input  logic [FINE_W-1:0] rxFineData,
  output logic [CNT_W-1:0]  txTotal,
  output logic [CNT_W-1:0]  rxTotal,
  output ctrlStrobes_t      strobes
);

  localparam int RX_LO  = 0;
  localparam int TX_LO  = DIV_SEL_W;
  localparam int PRE_LO = 2 * DIV_SEL_W;

  logic [RATE_W-1:0] rateReg;
  logic [FINE_W-1:0] txFine;
  logic [FINE_W-1:0] rxFine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateReg <= '0;
      txFine  <= '0;
      rxFine  <= '0;
      strobes <= '0;
    end else begin
      if (rateWe)   rateReg <= rateData;
      if (txFineWe) txFine  <= txFineData;
      if (rxFineWe) rxFine  <= rxFineData;
      strobes.reloadTx <= rateWe | txFineWe;
      strobes.reloadRx <= rateWe | rxFineWe;
    end
  end

  logic [PRE_SEL_W-1:0] preSel;
  logic [DIV_SEL_W-1:0] txSel;
  logic [DIV_SEL_W-1:0] rxSel;
  logic [3:0]           preVal;

  assign preSel = rateReg[PRE_LO +: PRE_SEL_W];
  assign txSel  = rateReg[TX_LO  +: DIV_SEL_W];
  assign rxSel  = rateReg[RX_LO  +: DIV_SEL_W];
  assign preVal = preFactor(preSel);

  function automatic logic [CNT_W-1:0] pathTotal(
    input logic [3:0]           pre,
    input logic [DIV_SEL_W-1:0] sel,
    input logic [FINE_W-1:0]    fine
  );
    logic [FINE_W-1:0] fineEff;
    logic [CNT_W-1:0]  base;
    fineEff = (fine == '0) ? FINE_W'(1) : fine;
    base = CNT_W'(pre) * CNT_W'(fineEff);
    pathTotal = base << sel;
  endfunction

  always_comb begin
    txTotal = pathTotal(preVal, txSel, txFine);
    rxTotal = pathTotal(preVal, rxSel, rxFine);
  end

endmodule

// File: rtl/rate_tick_dp.sv
module rate_tick_dp
  import rate_tick_pkg::*;
#(
  parameter int CNT_W   = 19,
  parameter int N_PATHS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [N_PATHS-1:0][CNT_W-1:0]  total,
  input  ctrlStrobes_t                   strobes,
  output logic [N_PATHS-1:0][CNT_W-1:0]  count,
  output logic [N_PATHS-1:0]             tick
);

  logic [N_PATHS-1:0] reload;
  assign reload[0] = strobes.reloadTx;
  assign reload[1] = strobes.reloadRx;

  for (genvar p = 0; p < N_PATHS; p++) begin : gPath
    always_ff @(posedge clk) begin
      if (!rstN) begin
        count[p] <= '0;
      end else if (reload[p] || count[p] == '0) begin
        count[p] <= total[p] - 1'b1;
      end else begin
        count[p] <= count[p] - 1'b1;
      end
    end
    assign tick[p] = (count[p] == '0);
  end

endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
  import rate_tick_pkg::*;
#(
  parameter int RATE_W    = 8,
  parameter int FINE_W    = 8,
  parameter int PRE_SEL_W = 2,
  parameter int DIV_SEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateWe,
  input  logic [RATE_W-1:0] rateData,
  input  logic              txFineWe,
  input  logic [FINE_W-1:0] txFineData,
  input  logic              rxFineWe,
  input  logic [FINE_W-1:0] rxFineData,
  output logic              txTick,
  output logic              rxTick
);

  localparam int CNT_W = 4 + (2**DIV_SEL_W - 1) + FINE_W;

  logic [CNT_W-1:0]      txTotal;
  logic [CNT_W-1:0]      rxTotal;
  ctrlStrobes_t          strobes;
  logic [1:0][CNT_W-1:0] pathCount;
  logic [1:0]            pathTick;
  logic [CNT_W-1:0]      txCount;
  logic [CNT_W-1:0]      rxCount;

  rate_tick_ctrl #(
    .RATE_W(RATE_W), .FINE_W(FINE_W), .PRE_SEL_W(PRE_SEL_W),
    .DIV_SEL_W(DIV_SEL_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .rateWe(rateWe), .rateData(rateData),
    .txFineWe(txFineWe), .txFineData(txFineData),
    .rxFineWe(rxFineWe), .rxFineData(rxFineData),
    .txTotal(txTotal), .rxTotal(rxTotal), .strobes(strobes)
  );

  rate_tick_dp #(.CNT_W(CNT_W), .N_PATHS(2)) uDp (
    .clk(clk), .rstN(rstN),
    .total({rxTotal, txTotal}),
    .strobes(strobes),
    .count(pathCount),
    .tick(pathTick)
  );

  assign txCount = pathCount[0];
  assign rxCount = pathCount[1];
  assign txTick  = pathTick[0];
  assign rxTick  = pathTick[1];

endmodule

// File: rtl/rate_tick_chk.sv
module rate_tick_chk #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             rateWe,
  input logic             txFineWe,
  input logic             rxFineWe,
  input logic             txTick,
  input logic             rxTick,
  input logic [CNT_W-1:0] txTotal,
  input logic [CNT_W-1:0] rxTotal,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             reloadTx,
  input logic             reloadRx
);

  // R8: two clocks after an isolated write, tick reflects the freshly loaded count
  p_tx_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    rateWe ##1 (!rateWe && !txFineWe) |=> (txTick == (txTotal == 1)));
  p_rx_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    rateWe ##1 (!rateWe && !rxFineWe) |=> (rxTick == (rxTotal == 1)));

  // R7: counters stay inside the current period when no reload is pending
  p_tx_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reloadTx |-> txCount < txTotal);
  p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reloadRx |-> rxCount < rxTotal);

  // R7: a nonzero count steps down by one
  p_tx_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!reloadTx && txCount != '0) |=> txCount == $past(txCount) - 1'b1);

  // R7: after a tick the count restarts at period minus one
  p_rx_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!reloadRx && rxTick) |=> rxCount == $past(rxTotal) - 1'b1);

  // R9: period one means the tick never drops
  p_tx_always_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!reloadTx && txTotal == 1 && $stable(txTotal)) |-> txTick);

endmodule

bind rate_tick_gen rate_tick_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .rateWe(rateWe), .txFineWe(txFineWe),
  .rxFineWe(rxFineWe), .txTick(txTick), .rxTick(rxTick),
  .txTotal(txTotal), .rxTotal(rxTotal), .txCount(txCount),
  .rxCount(rxCount), .reloadTx(strobes.reloadTx),
  .reloadRx(strobes.reloadRx)
);

// File: tb/tb_rate_tick_gen.sv
`timescale 1ns/1ps
module tb_rate_tick_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rateWe = 1'b0;
  logic [7:0] rateData = '0;
  logic       txFineWe = 1'b0;
  logic [7:0] txFineData = '0;
  logic       rxFineWe = 1'b0;
  logic [7:0] rxFineData = '0;
  logic       txTick;
  logic       rxTick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #10 clk = ~clk;   // 50 MHz

  rate_tick_gen dut (
    .clk(clk), .rstN(rstN),
    .rateWe(rateWe), .rateData(rateData),
    .txFineWe(txFineWe), .txFineData(txFineData),
    .rxFineWe(rxFineWe), .rxFineData(rxFineData),
    .txTick(txTick), .rxTick(rxTick)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 200000", cycles);
      summary();
    end
  end

  // R2 prescale factor
  function automatic int expPre(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 3;
      2'd2: return 4;
      default: return 13;
    endcase
  endfunction

  // R1, R3, R4, R5: period of a path
  function automatic int expPeriod(input logic [7:0] rate, input logic [7:0] fine, input bit isTx);
    int sel;
    sel = isTx ? int'(rate[5:3]) : int'(rate[2:0]);
    return expPre(rate[7:6]) * (1 << sel) * ((fine == 0) ? 1 : int'(fine));
  endfunction

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    case (which)
      0: begin rateWe = 1; rateData = d; end
      1: begin txFineWe = 1; txFineData = d; end
      default: begin rxFineWe = 1; rxFineData = d; end
    endcase
    @(negedge clk);
    rateWe = 0; txFineWe = 0; rxFineWe = 0;
  endtask

  // Apply setting and compare both tick streams each clock (R7, R8)
  task automatic runCase(input string tag, input logic [7:0] rate,
                         input logic [7:0] tf, input logic [7:0] rf);
    int dT, dR, len, badT, badR, firstT, firstR;
    bit eT, eR, aT, aR, fT, fR;
    wr(1, tf);
    wr(2, rf);
    dT = expPeriod(rate, tf, 1);
    dR = expPeriod(rate, rf, 0);
    len = 2 * ((dT > dR) ? dT : dR) + 1;
    badT = 0; badR = 0; firstT = 0; firstR = 0;
    fT = 0; fR = 0; aT = 0; aR = 0;
    // write edge E lies between these negedges; index 1 is the first negedge after E
    @(negedge clk);
    rateWe = 1; rateData = rate;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      rateWe = 0;
      if (n >= 2) begin
        eT = (n >= dT + 1) && ((n - 1) % dT == 0);
        eR = (n >= dR + 1) && ((n - 1) % dR == 0);
        if (txTick !== eT) begin badT++; if (!fT) begin fT = 1; firstT = n; aT = txTick; end end
        if (rxTick !== eR) begin badR++; if (!fR) begin fR = 1; firstR = n; aR = rxTick; end end
      end
    end
    checks++;
    if (badT != 0) begin
      fails++;
      $display("FAIL R7/R8 tx %s rate=%h fine=%h period %0d: clock %0d actual %0b expected %0b",
               tag, rate, tf, dT, firstT, aT, !aT);
    end
    checks++;
    if (badR != 0) begin
      fails++;
      $display("FAIL R7/R8 rx %s rate=%h fine=%h period %0d: clock %0d actual %0b expected %0b",
               tag, rate, rf, dR, firstR, aR, !aR);
    end
  endtask

  initial begin
    logic [7:0] r, tf, rf;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R6, R9: after reset both periods are 1
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      checks++;
      if (txTick !== 1'b1 || rxTick !== 1'b1) begin
        fails++;
        $display("FAIL R6 reset ticks: actual tx=%0b rx=%0b expected 1 1", txTick, rxTick);
      end
    end
    runCase("R2 pre3", 8'h40, 8'h00, 8'h00);
    runCase("R2 pre4", 8'h80, 8'h00, 8'h00);
    runCase("R2 pre13", 8'hC0, 8'h00, 8'h00);
    runCase("R3 split sel", 8'h0A, 8'h00, 8'h00);
    runCase("R4 max plain", 8'hFF, 8'h00, 8'h00);
    runCase("R5 fine", 8'h48, 8'h03, 8'h07);
    runCase("R9 period1", 8'h00, 8'h00, 8'h00);
    runCase("R5 fine one", 8'h00, 8'h01, 8'h02);
    runCase("R1 fields", 8'h51, 8'h00, 8'h05);
    for (int i = 0; i < 18; i++) begin
      do begin
        r  = 8'($urandom);
        tf = ($urandom % 2) ? 8'($urandom) : 8'h00;
        rf = ($urandom % 2) ? 8'($urandom) : 8'h00;
      end while (expPeriod(r, tf, 1) > 1200 || expPeriod(r, rf, 0) > 1200);
      runCase("R4 R5 random", r, tf, rf);
    end
    // return to period 1 directly from a long period (R8, R9)
    runCase("R8 long", 8'hC4, 8'h00, 8'h00);
    runCase("R9 back to 1", 8'h00, 8'h00, 8'h00);
    done = 1;
    summary();
  end

endmodule